// File: doc/BRIEF.md
# Status Calendar Sequence Generator

This block produces the 2-bit flow-control status stream that a packet receiver sends back to its transmitter. A programmable calendar lists port numbers. The block walks that list a programmable number of times, reporting the live status of each named port. It then closes the sequence with a 2-bit parity symbol and a framing symbol, and starts again. A port that needs more frequent credit updates is given several calendar entries, spread through the list.

The stream leaves on `sym`, with `sym_valid` marking the first cycle of each status slot. It is free-running and has no back-pressure. A slot lasts one clock in fast mode and `SLOW_DIV` clocks in slow mode, and the sink must take each slot as it comes. The calendar length and repeat count are captured only when a framing slot is emitted. This lets software reprogram them at any time without tearing a sequence in half.

Top module: `status_calendar`

## Requirements
- R1: While `rst_n` is low, `sym` is 2'b11 and `sym_valid` and `frame_start` are 0. The first slot emitted after reset is a framing slot.
- R2: Port status codes are 2'b00 starving, 2'b01 hungry and 2'b10 satisfied. The framing slot carries 2'b11. `frame_start` is high on the framing slot and on no other slot.
- R3: Each sequence is one framing slot, then `cal_len*cal_m` calendar slots, then one parity slot, then the next framing slot. Framing slots are therefore `cal_len*cal_m+2` slots apart.
- R4: Calendar slot k of a sequence (counting from 0) reports the status of the port held in table entry `k mod cal_len`. Entry i sits at `cal_table[i*PORT_W +: PORT_W]`, and port p's status sits at `port_status[2p+1:2p]`. The same port may appear in several entries.
- R5: The parity slot carries the bitwise XOR of all calendar symbols sent since the preceding framing slot.
- R6: A port's status is taken at the clock edge that starts its slot. A value applied before that edge is reported, even if it changed after the previous slot.
- R7: When `slow_mode` is 0, a new slot starts every clock and `sym_valid` stays high. When `slow_mode` is 1, a slot starts every `SLOW_DIV` (default 4) clocks, `sym_valid` is high only in the first cycle of the slot, and `sym` holds its value in between.
- R8: `cal_len` and `cal_m` are captured when a framing slot is emitted. Changes made at other times do not affect the sequence in progress.
- R9: A captured `cal_len` of 0 acts as 1, and a value above `MAX_CAL` acts as `MAX_CAL`. A captured `cal_m` of 0 acts as 1.
- R10: A table entry that names a port number at or above `NUM_PORTS` reports satisfied (2'b10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_mode | input | 1 | 1: one slot per SLOW_DIV clocks; 0: one slot per clock |
| port_status | input | NUM_PORTS*2 | Live status of every port, two bits per port |
| cal_table | input | MAX_CAL*PORT_W | Calendar entries, PORT_W bits each |
| cal_len | input | LEN_W | Number of calendar entries used |
| cal_m | input | M_W | Number of passes over the calendar per sequence |
| sym | output | 2 | Status symbol of the current slot |
| sym_valid | output | 1 | First cycle of a new slot |
| frame_start | output | 1 | Current slot is the framing slot |

## Verification
The slot-rate assertions assume `slow_mode` is held for at least two clocks before they judge slot spacing. The bench changes the mode only between whole measurements and lets several slots pass after a switch. The configuration assertions assume nothing about `cal_len` or `cal_m`, because out-of-range values are clamped at capture. The bench drives zero and oversized values on purpose. The bench changes configuration inputs only at falling edges. Status values in the sampling test are changed in the cycle just before each slot's starting edge.

// File: rtl/scal_pkg.sv
package scal_pkg;
  typedef enum logic [1:0] {
    PH_FRAME = 2'd0,
    PH_CAL   = 2'd1,
    PH_DIP   = 2'd2
  } phase_e;

  localparam logic [1:0] ST_STARVING  = 2'b00;
  localparam logic [1:0] ST_HUNGRY    = 2'b01;
  localparam logic [1:0] ST_SATISFIED = 2'b10;
  localparam logic [1:0] SYM_FRAME    = 2'b11;
endpackage

// File: rtl/scal_rate_div.sv
module scal_rate_div #(
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_mode,
  output logic tick
);
  localparam int CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(SLOW_DIV - 1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = slow_mode ? (cnt_q == '0) : 1'b1;
endmodule

// File: rtl/scal_walker.sv
module scal_walker
  import scal_pkg::*;
#(
  parameter int MAX_CAL = 16,
  parameter int M_W     = 4,
  parameter int LEN_W   = $clog2(MAX_CAL + 1),
  parameter int IDX_W   = $clog2(MAX_CAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [LEN_W-1:0] cal_len,
  input  logic [M_W-1:0]   cal_m,
  output phase_e           phase,
  output logic [IDX_W-1:0] idx
);
  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] len_q, len_eff;
  logic [M_W-1:0]   m_q, rep_q, m_eff;
  logic             last_entry, last_pass;

  always_comb begin
    len_eff = cal_len;
    if (cal_len == '0) begin
      len_eff = LEN_W'(1);
    end else if (cal_len > LEN_W'(MAX_CAL)) begin
      len_eff = LEN_W'(MAX_CAL);
    end
    m_eff = (cal_m == '0) ? M_W'(1) : cal_m;
  end

  assign last_entry = (LEN_W'(idx_q) == len_q - 1'b1);
  assign last_pass  = (rep_q == m_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_FRAME;
      idx_q   <= '0;
      rep_q   <= '0;
      len_q   <= LEN_W'(1);
      m_q     <= M_W'(1);
    end else if (tick) begin
      case (phase_q)
        PH_FRAME: begin
          len_q   <= len_eff;
          m_q     <= m_eff;
          idx_q   <= '0;
          rep_q   <= '0;
          phase_q <= PH_CAL;
        end
        PH_CAL: begin
          if (last_entry) begin
            idx_q <= '0;
            if (last_pass) begin
              phase_q <= PH_DIP;
            end else begin
              rep_q <= rep_q + 1'b1;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: phase_q <= PH_FRAME;
      endcase
    end
  end

  assign phase = phase_q;
  assign idx   = idx_q;

  AST_IDX_IN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CAL) |-> (LEN_W'(idx_q) < len_q)); // R3
  AST_FRAME_THEN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && phase_q == PH_FRAME) |=> (phase_q == PH_CAL)); // R3
  AST_DIP_THEN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && phase_q == PH_DIP) |=> (phase_q == PH_FRAME)); // R3
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick && phase_q == PH_FRAME) |-> ($stable(len_q) && $stable(m_q))); // R8
  AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) && (len_q <= LEN_W'(MAX_CAL)) && (m_q != '0)); // R9
endmodule

// File: rtl/scal_dip.sv
module scal_dip (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       clr,
  input  logic       accum,
  input  logic [1:0] sym_in,
  output logic [1:0] dip
);
  logic [1:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (tick) begin
      if (clr) begin
        acc_q <= '0;
      end else if (accum) begin
        acc_q <= acc_q ^ sym_in;
      end
    end
  end

  assign dip = acc_q;
endmodule

// File: rtl/status_calendar.sv
module status_calendar
  import scal_pkg::*;
#(
  parameter int NUM_PORTS = 10,
  parameter int MAX_CAL   = 16,
  parameter int M_W       = 4,
  parameter int SLOW_DIV  = 4,
  parameter int PORT_W    = $clog2(NUM_PORTS),
  parameter int LEN_W     = $clog2(MAX_CAL + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      slow_mode,
  input  logic [NUM_PORTS*2-1:0]    port_status,
  input  logic [MAX_CAL*PORT_W-1:0] cal_table,
  input  logic [LEN_W-1:0]          cal_len,
  input  logic [M_W-1:0]            cal_m,
  output logic [1:0]                sym,
  output logic                      sym_valid,
  output logic                      frame_start
);
  localparam int IDX_W = $clog2(MAX_CAL);

  logic              tick;
  phase_e            phase;
  logic [IDX_W-1:0]  idx;
  logic [PORT_W-1:0] entry;
  logic [1:0]        cal_sym, dip, next_sym;
  logic [1:0]        stat_arr [NUM_PORTS];

  scal_rate_div #(.SLOW_DIV(SLOW_DIV)) u_rate (
    .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .tick(tick)
  );

  scal_walker #(.MAX_CAL(MAX_CAL), .M_W(M_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cal_len(cal_len), .cal_m(cal_m),
    .phase(phase), .idx(idx)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_stat
    assign stat_arr[p] = port_status[p*2 +: 2];
  end

  assign entry = cal_table[idx*PORT_W +: PORT_W];

  always_comb begin
    cal_sym = ST_SATISFIED;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (entry == PORT_W'(p)) cal_sym = stat_arr[p];
    end
  end

  scal_dip u_dip (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .clr(phase == PH_FRAME), .accum(phase == PH_CAL),
    .sym_in(cal_sym), .dip(dip)
  );

  always_comb begin
    case (phase)
      PH_CAL:  next_sym = cal_sym;
      PH_DIP:  next_sym = dip;
      default: next_sym = SYM_FRAME;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym         <= SYM_FRAME;
      sym_valid   <= 1'b0;
      frame_start <= 1'b0;
    end else if (tick) begin
      sym         <= next_sym;
      sym_valid   <= 1'b1;
      frame_start <= (phase == PH_FRAME);
    end else begin
      sym_valid   <= 1'b0;
    end
  end

  AST_FRAME_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (sym == SYM_FRAME)); // R2
  AST_FAST_EVERY_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (!slow_mode && !$past(slow_mode) && $past(rst_n)) |-> sym_valid); // R7
  AST_SLOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_mode && $past(slow_mode) && $past(slow_mode, 2) && $past(sym_valid)) |-> !sym_valid); // R7
  AST_SYM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |-> $stable(sym)); // R7
endmodule

// File: tb/tb_status_calendar.sv
module tb_status_calendar;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 10;
  localparam int MC = 16;
  localparam int PW = 4;
  localparam int LW = 5;
  localparam int MW = 4;
  localparam int NROW = 8;

  // raw len, raw m, effective len, effective m
  localparam int V_LEN [NROW] = '{4, 3, 1, 0, 16, 20, 5, 2};
  localparam int V_M   [NROW] = '{1, 2, 1, 0, 1, 2, 3, 7};
  localparam int V_EL  [NROW] = '{4, 3, 1, 1, 16, 16, 5, 2};
  localparam int V_EM  [NROW] = '{1, 2, 1, 1, 1, 2, 3, 7};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_mode = 1'b0;
  logic [NP*2-1:0] port_status = '0;
  logic [MC*PW-1:0] cal_table = '0;
  logic [LW-1:0] cal_len = '0;
  logic [MW-1:0] cal_m = '0;
  logic [1:0] sym;
  logic sym_valid, frame_start;

  int tb_tab [MC];
  int tb_stat [NP];
  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  status_calendar #(.NUM_PORTS(NP), .MAX_CAL(MC), .M_W(MW), .SLOW_DIV(4)) dut (
    .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .port_status(port_status),
    .cal_table(cal_table), .cal_len(cal_len), .cal_m(cal_m),
    .sym(sym), .sym_valid(sym_valid), .frame_start(frame_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic drive();
    for (int i = 0; i < MC; i++) cal_table[i*PW +: PW] = PW'(tb_tab[i]);
    for (int p = 0; p < NP; p++) port_status[p*2 +: 2] = 2'(tb_stat[p]);
  endtask

  function automatic logic [1:0] exp_sym(input int k, input int len);
    int e;
    e = tb_tab[k % len];
    return (e < NP) ? 2'(tb_stat[e]) : 2'b10;  // R10
  endfunction

  task automatic next_slot();
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!sym_valid && g < 20);
  endtask

  task automatic wait_frame();
    int g = 0;
    do begin
      next_slot();
      g++;
    end while (!frame_start && g < 100);
    chk({1'b0, frame_start}, 2'b01, "R3 framing reached");
  endtask

  // Entered at the negedge showing a framing slot; leaves at the next one.
  task automatic check_seq(input int len, input int m, input bit vary, input string req);
    logic [1:0] acc = 2'b00;
    logic [1:0] e;
    for (int k = 0; k < len * m; k++) begin
      if (vary) begin
        tb_stat[0] = k % 3;
        drive();
      end
      next_slot();
      e = exp_sym(k, len);
      chk(sym, e, req);
      chk({1'b0, frame_start}, 2'b00, "R2 no frame mid-sequence");
      acc = acc ^ e;
    end
    next_slot();
    chk(sym, acc, "R5 parity slot");
    chk({1'b0, frame_start}, 2'b00, "R3 parity not framing");
    next_slot();
    chk({1'b0, frame_start}, 2'b01, "R3 period len*m+2");
    chk(sym, 2'b11, "R2 framing code");
  endtask

  initial begin
    logic [1:0] held;
    for (int i = 0; i < MC; i++) tb_tab[i] = 0;
    for (int p = 0; p < NP; p++) tb_stat[p] = 0;
    cal_len = LW'(4);
    cal_m = MW'(1);
    drive();

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(sym, 2'b11, "R1 reset sym");
    chk({sym_valid, frame_start}, 2'b00, "R1 reset flags");
    rst_n = 1'b1;
    @(negedge clk);
    chk({sym_valid, frame_start}, 2'b11, "R1 first slot is framing");

    // Vector table: R4, R9, R10 (entries 10 and 11 are out of range)
    for (int r = 0; r < NROW; r++) begin
      cal_len = LW'(V_LEN[r]);
      cal_m = MW'(V_M[r]);
      for (int i = 0; i < MC; i++) tb_tab[i] = (i * 3 + r) % 12;
      for (int p = 0; p < NP; p++) tb_stat[p] = (p + r) % 3;
      drive();
      wait_frame();
      check_seq(V_EL[r], V_EM[r], 1'b0, "R4/R9/R10 calendar slot");
    end

    // R8: change after capture waits for the next framing slot
    for (int i = 0; i < MC; i++) tb_tab[i] = i % NP;
    for (int p = 0; p < NP; p++) tb_stat[p] = (p * 2) % 3;
    cal_len = LW'(3);
    cal_m = MW'(1);
    drive();
    wait_frame();
    cal_len = LW'(5);
    cal_m = MW'(2);
    check_seq(3, 1, 1'b0, "R8 old config kept");
    check_seq(5, 2, 1'b0, "R8 new config applied");

    // R6: status changed just before each slot's edge
    for (int i = 0; i < MC; i++) tb_tab[i] = (i % 2 == 0) ? 0 : 1;
    cal_len = LW'(4);
    cal_m = MW'(2);
    drive();
    wait_frame();
    check_seq(4, 2, 1'b1, "R6 live sampling");

    // R7 slow mode
    slow_mode = 1'b1;
    wait_frame();
    wait_frame();
    check_seq(4, 2, 1'b1, "R7 slow sequence");
    next_slot();
    held = sym;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk({1'b0, sym_valid}, 2'b00, "R7 slow gap");
      chk(sym, held, "R7 slow hold");
    end
    @(negedge clk);
    chk({1'b0, sym_valid}, 2'b01, "R7 slow next slot");
    slow_mode = 1'b0;
    repeat (2) @(negedge clk);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk({1'b0, sym_valid}, 2'b01, "R7 fast every clock");
    end
    wait_frame();
    check_seq(4, 2, 1'b0, "R7 fast sequence");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule